// File: doc/BRIEF.md
# Receive Word Parity Marking and Acceptance Filter

This block sits right after the serial receiver, which assembles each 32-bit word. It takes one word per valid strobe. When parity checking is on, it replaces the top bit with an odd-parity verdict. It then decides whether the word goes to the receive FIFO. The FIFO itself lies outside this block. The decision is made in two steps, in a fixed order. First, an optional comparison of two word bits against programmed reference values. Second, an optional per-label enable looked up in a 256-entry, 1-bit memory.

Every valid word updates the registered output data, with the parity bit already replaced. Two strobes are produced for each word:
- The FIFO write strobe, raised only for words that clear both filter steps.
- A separate S/D-pass strobe, raised for every word that clears the first step. Downstream mailbox logic uses it to do its own label matching.

The label memory has its own write port. After reset, every label is disabled.

Top module: `rx_accept_filter`

## Requirements
- R1: While reset is asserted, and until the first valid word after reset, `fifo_we_o` and `sd_pass_o` are 0 and `fifo_data_o` is all zeros. After reset, every label memory entry reads 0, so with the label filter on no word is loaded until an entry is written.
- R2: With `par_en_i` = 1, `fifo_data_o[31]` becomes 0 if the number of ones across all 32 input bits is odd, and 1 if it is even. Bits 30..0 are passed unchanged.
- R3: With `par_en_i` = 0, `fifo_data_o` equals the input word exactly.
- R4: With `sd_en_i` = 1, a word is passed by the S/D step only when `word_i[8]` equals `sd_ref_i[0]` and `word_i[9]` equals `sd_ref_i[1]`. On a mismatch, neither `sd_pass_o` nor `fifo_we_o` is raised for that word.
- R5: With `sd_en_i` = 0, every valid word raises `sd_pass_o`.
- R6: With `lbl_filt_en_i` = 0, every word that passes the S/D step raises `fifo_we_o`. `fifo_we_o` is never raised without `sd_pass_o`.
- R7: With `lbl_filt_en_i` = 1, a word that passes the S/D step raises `fifo_we_o` only if the label memory entry addressed by `word_i[7:0]` holds 1.
- R8: `fifo_we_o` and `sd_pass_o` rise exactly one clock after the cycle in which `word_vld_i` was 1, last one cycle, and are never raised in a cycle that follows one without `word_vld_i`.
- R9: A label memory write (`lmem_we_i`, `lmem_addr_i`, `lmem_din_i`) takes effect at the clock edge. A word presented in the same cycle as a write to its own label still sees the old entry. Words in later cycles see the new value.
- R10: `fifo_data_o` updates for every valid word, whatever the filter outcome, and holds its value in cycles without `word_vld_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_i | input | 32 | Assembled received word; bit index 0 is word bit 1 |
| word_vld_i | input | 1 | One-cycle strobe marking `word_i` as a new word |
| par_en_i | input | 1 | Enable odd-parity check and bit-32 replacement |
| sd_en_i | input | 1 | Enable S/D bit comparison |
| sd_ref_i | input | 2 | Reference for word bits 10 (index 1) and 9 (index 0) |
| lbl_filt_en_i | input | 1 | Enable per-label memory filter |
| lmem_we_i | input | 1 | Label memory write enable |
| lmem_addr_i | input | 8 | Label memory write address |
| lmem_din_i | input | 1 | Label memory write data (1 = label enabled) |
| fifo_we_o | output | 1 | FIFO write strobe |
| sd_pass_o | output | 1 | Word passed the S/D step (to mailbox logic) |
| fifo_data_o | output | 32 | Processed word for the FIFO and mailboxes |

## Verification
The assertions assume the control inputs are stable within the cycle that carries the valid strobe, and that `word_vld_i` and the label-memory write inputs are free of unknown values once reset has been released. The bench drives every input on the falling edge and holds it through the next rising edge, so each word is seen with one consistent set of controls. It keeps all inputs at defined values from time zero. It idles through the reset-release window before any word or memory write is issued. The randomized phase changes the controls from word to word, but only between edges.

// File: rtl/rx_accept_pkg.sv
`timescale 1ns/1ps
package rx_accept_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LABEL_W  = 8;
  localparam int unsigned LABEL_N  = 1 << LABEL_W;
  localparam int unsigned SD_LO    = 8;   // index of word bit 9
  localparam int unsigned SD_W     = 2;
  localparam int unsigned FLAG_IDX = WORD_W - 1;

  typedef struct packed {
    logic              par_en;
    logic              sd_en;
    logic [SD_W-1:0]   sd_ref;
    logic              lbl_en;
  } filt_ctrl_t;
endpackage

// File: rtl/rfa_rst_sync.sv
`timescale 1ns/1ps
module rfa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rfa_parity_mark.sv
`timescale 1ns/1ps
module rfa_parity_mark #(
  parameter int unsigned W        = 32,
  parameter int unsigned FLAG_POS = W - 1
) (
  input  logic [W-1:0] word_i,
  input  logic         en_i,
  output logic [W-1:0] word_o
);
  logic ones_odd;

  // odd number of ones over the whole word, flag bit included
  always_comb begin
    ones_odd = 1'b0;
    for (int i = 0; i < W; i++) ones_odd = ones_odd ^ word_i[i];
  end

  always_comb begin
    word_o = word_i;
    if (en_i) word_o[FLAG_POS] = ~ones_odd;  // 0 = pass, 1 = fail
  end
endmodule

// File: rtl/rfa_sd_check.sv
`timescale 1ns/1ps
module rfa_sd_check #(
  parameter int unsigned SDW = 2
) (
  input  logic [SDW-1:0] sd_bits_i,
  input  logic [SDW-1:0] sd_ref_i,
  input  logic           en_i,
  output logic           pass_o
);
  logic [SDW-1:0] diff;

  always_comb begin
    diff   = sd_bits_i ^ sd_ref_i;
    pass_o = !en_i || (diff == '0);
  end
endmodule

// File: rtl/rfa_label_mem.sv
`timescale 1ns/1ps
module rfa_label_mem #(
  parameter int unsigned AW    = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rdata_o
);
  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bit_en;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_entry
      always_comb begin
        bit_en[g] = we_i && (waddr_i == AW'(g));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bits_q[g] <= 1'b0;
        else if (bit_en[g]) bits_q[g] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = bits_q[raddr_i];

  // R9
  lmem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (bits_q[$past(waddr_i)] == $past(wdata_i)));

  // R9
  lmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(bits_q));
endmodule

// File: rtl/rx_accept_filter.sv
`timescale 1ns/1ps
module rx_accept_filter
  import rx_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              par_en_i,
  input  logic              sd_en_i,
  input  logic [SD_W-1:0]   sd_ref_i,
  input  logic              lbl_filt_en_i,
  input  logic              lmem_we_i,
  input  logic [LABEL_W-1:0] lmem_addr_i,
  input  logic              lmem_din_i,
  output logic              fifo_we_o,
  output logic              sd_pass_o,
  output logic [WORD_W-1:0] fifo_data_o
);
  logic              rst_s_n;
  filt_ctrl_t        ctrl;
  logic [WORD_W-1:0] marked_word;
  logic              sd_ok;
  logic              lbl_bit;
  logic              lbl_ok;

  logic              we_d, we_q;
  logic              sdp_d, sdp_q;
  logic [WORD_W-1:0] data_q;
  logic              data_en;

  assign ctrl = '{par_en: par_en_i, sd_en: sd_en_i, sd_ref: sd_ref_i,
                  lbl_en: lbl_filt_en_i};

  rfa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  rfa_parity_mark #(.W(WORD_W), .FLAG_POS(FLAG_IDX)) u_par (
    .word_i (word_i),
    .en_i   (ctrl.par_en),
    .word_o (marked_word)
  );

  rfa_sd_check #(.SDW(SD_W)) u_sd (
    .sd_bits_i (word_i[SD_LO +: SD_W]),
    .sd_ref_i  (ctrl.sd_ref),
    .en_i      (ctrl.sd_en),
    .pass_o    (sd_ok)
  );

  rfa_label_mem #(.AW(LABEL_W)) u_lmem (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .we_i    (lmem_we_i),
    .waddr_i (lmem_addr_i),
    .wdata_i (lmem_din_i),
    .raddr_i (word_i[LABEL_W-1:0]),
    .rdata_o (lbl_bit)
  );

  // next state: S/D stage first, label stage after it
  always_comb begin
    lbl_ok  = !ctrl.lbl_en || lbl_bit;
    sdp_d   = word_vld_i && sd_ok;
    we_d    = sdp_d && lbl_ok;
    data_en = word_vld_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      we_q  <= 1'b0;
      sdp_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      sdp_q <= sdp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     data_q <= '0;
    else if (data_en) data_q <= marked_word;
  end

  assign fifo_we_o   = we_q;
  assign sd_pass_o   = sdp_q;
  assign fifo_data_o = data_q;

  // R8
  strobe_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !word_vld_i |=> (!fifo_we_o && !sd_pass_o));

  // R6
  fifo_needs_sd_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    fifo_we_o |-> sd_pass_o);

  // R4
  sd_mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && sd_en_i && (word_i[SD_LO +: SD_W] != sd_ref_i))
      |=> (!sd_pass_o && !fifo_we_o));

  // R5
  sd_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && !sd_en_i) |=> sd_pass_o);

  // R6
  lbl_off_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && !lbl_filt_en_i && sd_ok) |=> fifo_we_o);

  // R7
  lbl_block_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && lbl_filt_en_i && !lbl_bit) |=> !fifo_we_o);

  // R2
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && par_en_i)
      |=> (fifo_data_o[FLAG_IDX] == ~(^$past(word_i))));

  // R3
  parity_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (word_vld_i && !par_en_i) |=> (fifo_data_o == $past(word_i)));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !word_vld_i |=> $stable(fifo_data_o));
endmodule

// File: tb/tb_rx_accept_filter.sv
`timescale 1ns/1ps
module tb_rx_accept_filter;
  logic        clk;
  logic        rst_n;
  logic [31:0] word_i;
  logic        word_vld_i;
  logic        par_en_i;
  logic        sd_en_i;
  logic [1:0]  sd_ref_i;
  logic        lbl_filt_en_i;
  logic        lmem_we_i;
  logic [7:0]  lmem_addr_i;
  logic        lmem_din_i;
  logic        fifo_we_o;
  logic        sd_pass_o;
  logic [31:0] fifo_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit          ref_mem [256];
  logic [31:0] exp_data;

  rx_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .par_en_i(par_en_i), .sd_en_i(sd_en_i), .sd_ref_i(sd_ref_i),
    .lbl_filt_en_i(lbl_filt_en_i), .lmem_we_i(lmem_we_i),
    .lmem_addr_i(lmem_addr_i), .lmem_din_i(lmem_din_i),
    .fifo_we_o(fifo_we_o), .sd_pass_o(sd_pass_o), .fifo_data_o(fifo_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at falling edge, predict, compare at next falling edge
  task automatic step(input bit v, input logic [31:0] w, input bit pe,
                      input bit se, input logic [1:0] sr, input bit le,
                      input bit mwe, input logic [7:0] ma, input bit md,
                      input string tag);
    int ones;
    bit sd_ok, lbl_ok, exp_we, exp_sdp;
    word_i = w; word_vld_i = v; par_en_i = pe; sd_en_i = se;
    sd_ref_i = sr; lbl_filt_en_i = le; lmem_we_i = mwe;
    lmem_addr_i = ma; lmem_din_i = md;
    sd_ok   = !se || (w[8] == sr[0] && w[9] == sr[1]);
    lbl_ok  = !le || ref_mem[w[7:0]];
    exp_sdp = v && sd_ok;
    exp_we  = exp_sdp && lbl_ok;
    if (v) begin
      ones = 0;
      for (int i = 0; i < 32; i++) if (w[i]) ones++;
      exp_data = w;
      if (pe) exp_data[31] = (ones % 2 == 1) ? 1'b0 : 1'b1;
    end
    if (mwe) ref_mem[ma] = md;
    @(posedge clk);
    @(negedge clk);
    check(fifo_we_o === exp_we,  tag, "fifo_we", 32'(fifo_we_o), 32'(exp_we));
    check(sd_pass_o === exp_sdp, tag, "sd_pass", 32'(sd_pass_o), 32'(exp_sdp));
    check(fifo_data_o === exp_data, tag, "data", fifo_data_o, exp_data);
  endtask

  task automatic idle(input string tag);
    step(0, 32'h0, 0, 0, 2'b00, 0, 0, 8'h00, 0, tag);
  endtask

  task automatic lwrite(input logic [7:0] a, input bit d, input string tag);
    step(0, 32'h0, 0, 0, 2'b00, 0, 1, a, d, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 1'b0;
    exp_data = 32'h0;
    rst_n = 1'b0; word_i = '0; word_vld_i = 0; par_en_i = 0; sd_en_i = 0;
    sd_ref_i = '0; lbl_filt_en_i = 0; lmem_we_i = 0; lmem_addr_i = '0;
    lmem_din_i = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check(fifo_we_o === 1'b0, "R1", "reset fifo_we", 32'(fifo_we_o), 0);
    check(sd_pass_o === 1'b0, "R1", "reset sd_pass", 32'(sd_pass_o), 0);
    check(fifo_data_o === 32'h0, "R1", "reset data", fifo_data_o, 0);
    rst_n = 1'b1;
    repeat (4) idle("R1");

    // R1: label memory clear after reset, label filter on
    step(1, 32'h0000_0012, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R1");
    step(1, 32'h1234_56FF, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R1");
    step(1, 32'h0000_0100, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R1");

    // R3 R5 R6: parity off, S/D off, label filter off
    step(1, 32'hDEAD_BEEF, 0, 0, 2'b00, 0, 0, 8'h00, 0, "R3");
    step(1, 32'h8000_0001, 0, 0, 2'b00, 0, 0, 8'h00, 0, "R6");
    idle("R10");
    idle("R8");
    step(1, 32'h0000_0300, 0, 0, 2'b11, 0, 0, 8'h00, 0, "R5");

    // R2: parity marking
    step(1, 32'h0000_0000, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");
    step(1, 32'hFFFF_FFFF, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");
    step(1, 32'h0000_0001, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");
    step(1, 32'h8000_0000, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");
    step(1, 32'h8000_0003, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");
    step(1, 32'h7FFF_FFFF, 1, 0, 2'b00, 0, 0, 8'h00, 0, "R2");

    // R4: S/D compare, every reference against every bit pair
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++)
        step(1, 32'h0000_0055 | (32'(b) << 8), 0, 1, 2'(r), 0, 0, 8'h00, 0, "R4");

    // R7: label filter with programmed entries
    lwrite(8'h5A, 1, "R7");
    lwrite(8'hFF, 1, "R7");
    step(1, 32'h0000_005A, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R7");
    step(1, 32'h0000_005B, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R7");
    step(1, 32'hABCD_00FF, 1, 0, 2'b00, 1, 0, 8'h00, 0, "R7");
    step(1, 32'h0000_025A, 0, 1, 2'b01, 1, 0, 8'h00, 0, "R7");
    step(1, 32'h0000_015A, 0, 1, 2'b01, 1, 0, 8'h00, 0, "R7");

    // R9: write and word in the same cycle, then the cycle after
    step(1, 32'h0000_0033, 0, 0, 2'b00, 1, 1, 8'h33, 1, "R9");
    step(1, 32'h0000_0033, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R9");
    step(1, 32'h0000_005A, 0, 0, 2'b00, 1, 1, 8'h5A, 0, "R9");
    step(1, 32'h0000_005A, 0, 0, 2'b00, 1, 0, 8'h00, 0, "R9");

    // R8: randomized words, controls and memory writes
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rw;
      rw = $urandom;
      rw[7:0] = 8'($urandom_range(0, 15)) ^ 8'h30;
      step(bit'($urandom_range(0, 1)), rw, bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           8'($urandom_range(0, 15)) ^ 8'h30, bit'($urandom_range(0, 1)), "R8");
    end
    idle("R10");
    finish_run();
  end
endmodule